// File: doc/BRIEF.md
# I2C Slave Transfer Engine

This block is the slave half of an I2C controller. It watches the serial clock and data lines through a synchronizer and a glitch filter, and it finds START and STOP conditions on the cleaned levels. After each START it shifts in an address byte. It compares the upper seven bits with a programmed own address. When the host enables it, it also accepts the all-zero general-call byte. It returns an acknowledge only when the interface is enabled and the host's acknowledge-enable flag is set.

Once addressed, the engine receives bytes from the external master or sends bytes to it. In both directions the bits move most significant first, paced by the master's clock. At every byte boundary the engine raises an interrupt with an 8-bit status code that names the event. It holds SCL low until the host clears the interrupt, and in that time the host reads the received byte or loads the next one to send. The engine reports a START or STOP that arrives inside a byte as a bus error and then lets go of both lines. A host stop request puts the engine back in the not-addressed state without putting anything on the bus.

Top module: `i2c_slave_engine`

## Requirements
- R1: An address byte whose bits 7:1 equal `addr_reg[7:1]` is acknowledged: SDA is pulled low during the ninth clock. Bit 0 of the byte is the direction, 0 for write and 1 for read. An own-address write raises status 60h. Any other address gets no acknowledge and raises no interrupt.
- R2: The engine acknowledges its own address or the general call only while both `enable` and `ack_en` are 1. While `enable` is 0 it drives neither line and does not track the bus.
- R3: When `addr_reg[0]` is 1, the byte 00h is the general call. It is acknowledged with status 70h. Data received after it gives 90h when acknowledged and 98h when not. When `addr_reg[0]` is 0, the byte 00h is not acknowledged.
- R4: If `arb_lost` is 1 when the address phase completes, the codes change: 68h replaces 60h, 78h replaces 70h, and B0h replaces A8h.
- R5: A received data byte is shifted in MSB first and appears on `rx_byte`. If `ack_en` is 1 the byte is acknowledged and the status is 80h. If `ack_en` is 0 there is no acknowledge, the status is 88h, and the engine becomes not addressed, so it ignores further bytes.
- R6: An own-address read gives status A8h. The byte on `tx_byte`, loaded with `tx_wr` before the interrupt is cleared, goes out MSB first. If the master acknowledges, the status is B8h. If it does not, the status is C0h and the engine becomes not addressed.
- R7: If `ack_en` is 0 when the interrupt is cleared in transmit mode, that byte is the last one. A master acknowledge after it gives C8h. The engine then leaves SDA released, so the master reads FFh, and it raises no further interrupt.
- R8: A START or STOP while addressed gives status A0h, without holding SCL, if it comes at a byte boundary. A byte boundary means no more than the first clock pulse of the next byte has been seen. A repeated START then starts a new address phase.
- R9: A START or STOP that comes while addressed, after two or more clock pulses of a byte, gives status 00h. Both lines are released, and the engine ignores the bus until a stop request.
- R10: A `stop_req` pulse drives nothing on the bus. The engine goes to the not-addressed state and clears `bus_busy`.
- R11: At the falling edge of the ninth clock of each byte event, SCL is held low, and it stays low until `irq_clr`. `irq` is high exactly while an event is pending. `status` reads F8h whenever no event is pending.
- R12: `bus_busy` is set by a START (SDA falling while SCL is high) and cleared by a STOP (SDA rising while SCL is high).
- R13: START and STOP are detected only on filtered levels. A level must stay stable for `FILT_LEN` clocks, so a 2-clock SDA pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_low | output | 1 | 1 pulls SCL low (clock hold) |
| sda_low | output | 1 | 1 pulls SDA low |
| enable | input | 1 | Interface enable |
| ack_en | input | 1 | Acknowledge-enable flag from the host |
| addr_reg | input | 8 | Own address in bits 7:1, general-call enable in bit 0 |
| arb_lost | input | 1 | Master side lost arbitration during this address |
| tx_wr | input | 1 | Load `tx_byte` into the shift register |
| tx_byte | input | 8 | Byte to send |
| rx_byte | output | 8 | Shift register contents (received byte) |
| irq_clr | input | 1 | Host clears the pending event |
| stop_req | input | 1 | Host recovery: act as if a STOP was received |
| irq | output | 1 | Event pending |
| status | output | 8 | Event code, F8h when idle |
| bus_busy | output | 1 | A START was seen and no STOP since |

## Verification
The hardest state to reach is the bus error. It needs the engine already addressed and an odd START partway through a data byte. It must also be told apart from the legal repeated START and STOP, whose first SCL rise also counts as a clock. The bench first completes an address phase. It then clocks three data bits by hand and issues a START, so the byte-position count is well past the boundary. It then checks that the address that follows is ignored until a stop request. A reference queue of expected status codes is compared against each rising edge of the interrupt, so any event that was not expected is flagged.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RX, S_TX, S_ERR} eng_state_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;

  localparam logic [7:0] ST_NONE        = 8'hF8;
  localparam logic [7:0] ST_BUSERR      = 8'h00;
  localparam logic [7:0] ST_RX_OWN      = 8'h60;
  localparam logic [7:0] ST_RX_OWN_AL   = 8'h68;
  localparam logic [7:0] ST_RX_GC       = 8'h70;
  localparam logic [7:0] ST_RX_GC_AL    = 8'h78;
  localparam logic [7:0] ST_RX_DAT_ACK  = 8'h80;
  localparam logic [7:0] ST_RX_DAT_NAK  = 8'h88;
  localparam logic [7:0] ST_GC_DAT_ACK  = 8'h90;
  localparam logic [7:0] ST_GC_DAT_NAK  = 8'h98;
  localparam logic [7:0] ST_END         = 8'hA0;
  localparam logic [7:0] ST_TX_OWN      = 8'hA8;
  localparam logic [7:0] ST_TX_OWN_AL   = 8'hB0;
  localparam logic [7:0] ST_TX_ACK      = 8'hB8;
  localparam logic [7:0] ST_TX_NAK      = 8'hC0;
  localparam logic [7:0] ST_TX_LAST     = 8'hC8;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

  assert_filter_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q[1])));
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
  import i2cs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    evt.scl_rise = scl_f & ~scl_q;
    evt.scl_fall = ~scl_f & scl_q;
    evt.start    = scl_f & scl_q & sda_q & ~sda_f;
    evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
    evt.sda      = sda_f;
  end
endmodule

// File: rtl/i2cs_slave_fsm.sv
module i2cs_slave_fsm
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_evt_t   evt,
  input  logic       enable,
  input  logic       ack_en,
  input  logic [7:0] addr_reg,
  input  logic       arb_lost,
  input  logic       tx_wr,
  input  logic [7:0] tx_byte,
  input  logic       irq_clr,
  input  logic       stop_req,
  output logic       scl_low,
  output logic       sda_low,
  output logic       irq,
  output logic [7:0] status,
  output logic [7:0] rx_byte,
  output logic       bus_busy
);
  eng_state_t state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, stat_q, stat_d;
  logic drv_q, drv_d, si_q, si_d, hold_q, hold_d, busy_q, busy_d;
  logic gc_q, gc_d, ackd_q, ackd_d, mack_q, mack_d, last_q, last_d;
  logic addressed, past_edge, own_hit, gc_hit;

  assign addressed = (state_q == S_RX) || (state_q == S_TX);
  assign past_edge = (cnt_q > 4'd1);
  assign own_hit   = (sh_q[7:1] == addr_reg[7:1]);
  assign gc_hit    = addr_reg[0] && (sh_q == 8'h00);

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; stat_d = stat_q;
    drv_d = drv_q; si_d = si_q; hold_d = hold_q; busy_d = busy_q;
    gc_d = gc_q; ackd_d = ackd_q; mack_d = mack_q; last_d = last_q;
    if (!enable) begin
      state_d = S_IDLE; cnt_d = '0; drv_d = 1'b0; si_d = 1'b0;
      hold_d = 1'b0; stat_d = ST_NONE; busy_d = 1'b0;
    end else if (stop_req) begin
      state_d = S_IDLE; cnt_d = '0; drv_d = 1'b0; hold_d = 1'b0; busy_d = 1'b0;
    end else if (state_q == S_ERR) begin
      if (evt.start) busy_d = 1'b1;
      if (evt.stop)  busy_d = 1'b0;
    end else if (evt.start || evt.stop) begin
      busy_d = evt.start; cnt_d = '0; drv_d = 1'b0;
      state_d = evt.start ? S_ADDR : S_IDLE;
      if (addressed) begin
        si_d = 1'b1; hold_d = 1'b0;
        if (past_edge) begin
          state_d = S_ERR; stat_d = ST_BUSERR;
        end else begin
          stat_d = ST_END;
        end
      end
    end else if (evt.scl_rise && state_q != S_IDLE) begin
      if (cnt_q < 4'd8) begin
        sh_d  = {sh_q[6:0], evt.sda};
        cnt_d = cnt_q + 4'd1;
      end else begin
        cnt_d  = 4'd9;
        mack_d = ~evt.sda;
      end
    end else if (evt.scl_fall && state_q != S_IDLE) begin
      unique case (state_q)
        S_ADDR: begin
          if (cnt_q == 4'd8) begin
            if (ack_en && (own_hit || gc_hit)) begin
              drv_d = 1'b1; gc_d = ~own_hit;
            end else begin
              state_d = S_IDLE; cnt_d = '0;
            end
          end else if (cnt_q == 4'd9) begin
            drv_d = 1'b0; cnt_d = '0; si_d = 1'b1; hold_d = 1'b1;
            if (sh_q[0]) begin
              state_d = S_TX;
              stat_d  = arb_lost ? ST_TX_OWN_AL : ST_TX_OWN;
            end else begin
              state_d = S_RX;
              if (gc_q) stat_d = arb_lost ? ST_RX_GC_AL  : ST_RX_GC;
              else      stat_d = arb_lost ? ST_RX_OWN_AL : ST_RX_OWN;
            end
          end
        end
        S_RX: begin
          if (cnt_q == 4'd8) begin
            drv_d = ack_en; ackd_d = ack_en;
          end else if (cnt_q == 4'd9) begin
            drv_d = 1'b0; cnt_d = '0; si_d = 1'b1; hold_d = 1'b1;
            if (gc_q) stat_d = ackd_q ? ST_GC_DAT_ACK : ST_GC_DAT_NAK;
            else      stat_d = ackd_q ? ST_RX_DAT_ACK : ST_RX_DAT_NAK;
            if (!ackd_q) state_d = S_IDLE;
          end
        end
        S_TX: begin
          if (cnt_q == 4'd8) begin
            drv_d = 1'b0;
          end else if (cnt_q == 4'd9) begin
            cnt_d = '0; si_d = 1'b1; hold_d = 1'b1;
            stat_d = !mack_q ? ST_TX_NAK : (last_q ? ST_TX_LAST : ST_TX_ACK);
            if (!mack_q || last_q) state_d = S_IDLE;
          end else if (cnt_q != 4'd0) begin
            drv_d = ~sh_q[7];
          end
        end
        default: ;
      endcase
    end
    if (enable && tx_wr) sh_d = tx_byte;
    if (enable && irq_clr && si_q) begin
      si_d = 1'b0; hold_d = 1'b0; stat_d = ST_NONE;
      if (state_d == S_TX && hold_q) begin
        drv_d  = ~sh_d[7];
        last_d = ~ack_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; cnt_q <= '0; sh_q <= '0; stat_q <= ST_NONE;
      drv_q <= 1'b0; si_q <= 1'b0; hold_q <= 1'b0; busy_q <= 1'b0;
      gc_q <= 1'b0; ackd_q <= 1'b0; mack_q <= 1'b0; last_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; stat_q <= stat_d;
      drv_q <= drv_d; si_q <= si_d; hold_q <= hold_d; busy_q <= busy_d;
      gc_q <= gc_d; ackd_q <= ackd_d; mack_q <= mack_d; last_q <= last_d;
    end
  end

  assign scl_low  = si_q & hold_q;
  assign sda_low  = drv_q;
  assign irq      = si_q;
  assign status   = stat_q;
  assign rx_byte  = sh_q;
  assign bus_busy = busy_q;

  assert_hold_needs_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> si_q);
  assert_idle_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !si_q |-> (stat_q == ST_NONE));
  assert_err_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ERR) |-> (!drv_q && !hold_q));
  assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_req) |=> (state_q == S_IDLE && !busy_q && !drv_q));
  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stop_req && evt.start) |=> busy_q);
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2cs_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       enable,
  input  logic       ack_en,
  input  logic [7:0] addr_reg,
  input  logic       arb_lost,
  input  logic       tx_wr,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  input  logic       irq_clr,
  input  logic       stop_req,
  output logic       irq,
  output logic [7:0] status,
  output logic       bus_busy
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NLINES-1:0] raw_lines, filt_lines;
  bus_evt_t          evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n_s), .raw(raw_lines[g]), .filt(filt_lines[g]));
  end

  i2cs_cond_detect u_det (
    .clk(clk), .rst_n(rst_n_s), .scl_f(filt_lines[1]), .sda_f(filt_lines[0]),
    .evt(evt));

  i2cs_slave_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .evt(evt), .enable(enable), .ack_en(ack_en),
    .addr_reg(addr_reg), .arb_lost(arb_lost), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .irq_clr(irq_clr), .stop_req(stop_req), .scl_low(scl_low), .sda_low(sda_low),
    .irq(irq), .status(status), .rx_byte(rx_byte), .bus_busy(bus_busy));
endmodule

// File: tb/i2c_slave_engine_bench.sv
module i2c_slave_engine_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic scl_low, sda_low, enable, ack_en, arb_lost, tx_wr, irq_clr, stop_req;
  logic irq, bus_busy;
  logic [7:0] addr_reg, tx_byte, rx_byte, status;
  logic bus_scl, bus_sda;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic irq_prev = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  assign bus_scl = m_scl & ~scl_low;
  assign bus_sda = m_sda & ~sda_low;

  i2c_slave_engine u_i2c_slave_engine (
    .clk(clk), .rst_n(rst_n), .scl_in(bus_scl), .sda_in(bus_sda),
    .scl_low(scl_low), .sda_low(sda_low), .enable(enable), .ack_en(ack_en),
    .addr_reg(addr_reg), .arb_lost(arb_lost), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .irq_clr(irq_clr), .stop_req(stop_req), .irq(irq),
    .status(status), .bus_busy(bus_busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // reference model: queue of expected event codes, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      chk("watchdog expired", 1, 0);
      summary();
    end
    if (rst_n) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) chk("R11 unexpected interrupt", status, 8'hF8);
        else chk("R11 event code", status, exp_q.pop_front());
      end
      if (!irq) chk("R11 idle status", status, 8'hF8);
      if (scl_low) chk("R11 hold only with irq", irq, 1);
    end
    irq_prev = irq;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl;
    int w = 0;
    while (!bus_scl && w < 5000) begin tick(1); w++; end
    if (!bus_scl) chk("R11 SCL held forever", 0, 1);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; wait_scl(); tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; wait_scl(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(Q); m_scl = 1'b1; wait_scl(); tick(Q);
    s = bus_sda; m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~mack, s);
  endtask

  task automatic load_tx(input logic [7:0] b);
    tx_byte = b; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic service(input string tag, input logic [7:0] code, input logic held);
    tick(4);
    chk({tag, " irq"}, irq, 1);
    chk({tag, " status"}, status, code);
    chk({tag, " R11 scl hold"}, scl_low, held);
  endtask

  task automatic clear_irq;
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(2);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    m_scl = 1'b1; m_sda = 1'b1; enable = 1'b0; ack_en = 1'b0; addr_reg = 8'h00;
    arb_lost = 1'b0; tx_wr = 1'b0; tx_byte = 8'h00; irq_clr = 1'b0; stop_req = 1'b0;
    rst_n = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset status", status, 8'hF8);
    chk("R11 reset scl_low", scl_low, 0);
    chk("R2 reset sda_low", sda_low, 0);
    chk("R12 reset busy", bus_busy, 0);

    addr_reg = {7'h5A, 1'b1}; enable = 1'b1; ack_en = 1'b1; tick(5);

    // R13: short SDA pulse while SCL high is filtered out
    m_sda = 1'b0; tick(2); m_sda = 1'b1; tick(20);
    chk("R13 glitch no start", bus_busy, 0);

    // R1 R5 R12: own write, data with and without ack
    bus_start();
    chk("R12 busy after start", bus_busy, 1);
    exp_q.push_back(8'h60); wr_byte(8'hB4, a);
    chk("R1 own address ack", a, 1);
    service("R1 own write", 8'h60, 1); clear_irq();
    exp_q.push_back(8'h80); wr_byte(8'h3C, a);
    chk("R5 data ack", a, 1);
    service("R5 data acked", 8'h80, 1);
    chk("R5 rx byte", rx_byte, 8'h3C); clear_irq();
    ack_en = 1'b0;
    exp_q.push_back(8'h88); wr_byte(8'h99, a);
    chk("R5 data nack", a, 0);
    service("R5 data not acked", 8'h88, 1);
    chk("R5 rx byte 2", rx_byte, 8'h99); clear_irq();
    ack_en = 1'b1;
    wr_byte(8'h55, a);
    chk("R5 not addressed after nack", a, 0);
    bus_stop();
    chk("R12 idle after stop", bus_busy, 0);

    // R1: foreign address
    bus_start(); wr_byte({7'h33, 1'b0}, a);
    chk("R1 foreign address ignored", a, 0); bus_stop();

    // R2: ack_en low
    ack_en = 1'b0; bus_start(); wr_byte(8'hB4, a);
    chk("R2 no ack with ack_en 0", a, 0); bus_stop(); ack_en = 1'b1;

    // R3: general call
    bus_start();
    exp_q.push_back(8'h70); wr_byte(8'h00, a);
    chk("R3 general call ack", a, 1);
    service("R3 gc", 8'h70, 1); clear_irq();
    exp_q.push_back(8'h90); wr_byte(8'h11, a);
    chk("R3 gc data ack", a, 1);
    service("R3 gc data", 8'h90, 1);
    chk("R3 gc rx byte", rx_byte, 8'h11); clear_irq();
    ack_en = 1'b0;
    exp_q.push_back(8'h98); wr_byte(8'h22, a);
    service("R3 gc data nack", 8'h98, 1); clear_irq();
    ack_en = 1'b1; bus_stop();
    addr_reg = {7'h5A, 1'b0};
    bus_start(); wr_byte(8'h00, a);
    chk("R3 gc disabled", a, 0); bus_stop();
    addr_reg = {7'h5A, 1'b1};

    // R4 R8: arbitration-lost codes, STOP at boundary
    arb_lost = 1'b1;
    bus_start(); exp_q.push_back(8'h68); wr_byte(8'hB4, a);
    service("R4 own after lost arb", 8'h68, 1); clear_irq();
    exp_q.push_back(8'hA0); bus_stop();
    service("R8 stop while addressed", 8'hA0, 0); clear_irq();
    bus_start(); exp_q.push_back(8'h78); wr_byte(8'h00, a);
    service("R4 gc after lost arb", 8'h78, 1); clear_irq();
    exp_q.push_back(8'hA0); bus_stop();
    service("R8 stop after gc", 8'hA0, 0); clear_irq();
    bus_start(); exp_q.push_back(8'hB0); wr_byte(8'hB5, a);
    service("R4 read after lost arb", 8'hB0, 1);
    load_tx(8'hFF); clear_irq();
    exp_q.push_back(8'hA0); bus_stop();
    service("R8 stop in transmit", 8'hA0, 0); clear_irq();
    arb_lost = 1'b0;

    // R6 R7: transmit
    bus_start(); exp_q.push_back(8'hA8); wr_byte(8'hB5, a);
    chk("R6 read address ack", a, 1);
    service("R6 own read", 8'hA8, 1);
    load_tx(8'hA5); clear_irq();
    exp_q.push_back(8'hB8); rd_byte(1'b1, d);
    chk("R6 tx data", d, 8'hA5);
    service("R6 tx acked", 8'hB8, 1);
    load_tx(8'h3C); ack_en = 1'b0; clear_irq();
    exp_q.push_back(8'hC8); rd_byte(1'b1, d);
    chk("R7 last byte data", d, 8'h3C);
    service("R7 last byte", 8'hC8, 1); clear_irq();
    ack_en = 1'b1;
    rd_byte(1'b0, d);
    chk("R7 released after last", d, 8'hFF);
    bus_stop();
    bus_start(); exp_q.push_back(8'hA8); wr_byte(8'hB5, a);
    service("R6 own read 2", 8'hA8, 1);
    load_tx(8'h0F); clear_irq();
    exp_q.push_back(8'hC0); rd_byte(1'b0, d);
    chk("R6 tx data 2", d, 8'h0F);
    service("R6 tx not acked", 8'hC0, 1); clear_irq();
    chk("R6 sda released", sda_low, 0);
    bus_stop();

    // R8: repeated START at a boundary
    bus_start(); exp_q.push_back(8'h60); wr_byte(8'hB4, a);
    service("R8 setup", 8'h60, 1); clear_irq();
    exp_q.push_back(8'h80); wr_byte(8'h77, a);
    service("R8 data", 8'h80, 1); clear_irq();
    exp_q.push_back(8'hA0); bus_start();
    service("R8 repeated start", 8'hA0, 0); clear_irq();
    exp_q.push_back(8'h60); wr_byte(8'hB4, a);
    chk("R8 readdressed ack", a, 1);
    service("R8 readdressed", 8'h60, 1); clear_irq();
    exp_q.push_back(8'hA0); bus_stop();
    service("R8 final stop", 8'hA0, 0); clear_irq();

    // R9 R10: START inside a byte, then recovery
    bus_start(); exp_q.push_back(8'h60); wr_byte(8'hB4, a);
    service("R9 setup", 8'h60, 1); clear_irq();
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b1, a);
    exp_q.push_back(8'h00); bus_start();
    service("R9 bus error", 8'h00, 0);
    chk("R9 sda released", sda_low, 0);
    chk("R12 busy in error", bus_busy, 1);
    wr_byte(8'hB4, a);
    chk("R9 bus ignored in error", a, 0);
    stop_req = 1'b1; irq_clr = 1'b1; tick(1); stop_req = 1'b0; irq_clr = 1'b0; tick(2);
    chk("R10 busy cleared", bus_busy, 0);
    chk("R10 irq cleared", irq, 0);
    chk("R10 nothing driven scl", scl_low, 0);
    chk("R10 nothing driven sda", sda_low, 0);
    bus_stop();
    bus_start(); exp_q.push_back(8'h60); wr_byte(8'hB4, a);
    chk("R10 works after recovery", a, 1);
    service("R10 after recovery", 8'h60, 1); clear_irq();
    exp_q.push_back(8'hA0); bus_stop();
    service("R10 stop", 8'hA0, 0); clear_irq();

    // R2: disabled interface
    enable = 1'b0; tick(2);
    bus_start(); wr_byte(8'hB4, a);
    chk("R2 disabled no ack", a, 0);
    chk("R2 disabled no busy", bus_busy, 0);
    bus_stop(); enable = 1'b1; tick(Q);

    chk("R11 all expected events seen", exp_q.size(), 0);
    summary();
  end
endmodule